// File: doc/BRIEF.md
# Scalar Load/Store Request Formatter

This block sits between the register-read stage and the data memory of a small scalar core. For each accepted load or store instruction it takes the instruction word, the value of the base register and the value of the data register, and it produces a registered memory request. The request holds the effective address. For stores it also holds the data moved into its byte lanes and a write mask. For loads it holds a right-shift amount, a read mask that selects sign or zero extension, and the register to write.

The access kind comes from a three-bit request index taken from the opcode. The low two bits of that index give the access size, and the index as a whole also selects the extension behaviour. Bit 29 of the instruction marks a store. Both data and mask are placed by one left shift of (3 − size) × 8 bits, so narrow accesses sit in the most significant lanes of the word. A combinational return path applies the held shift and read mask to the word that memory returns. This gives the final load value, so the block can be exercised from end to end.

Top module: `lsu_req_fmt`

## Requirements
- R1: The request address equals the base value plus the instruction's low 16 bits sign-extended to 32 bits, wrapping modulo 2^32.
- R2: The size code is instruction bits [27:26] (the low two bits of the index in bits [28:26]), and the held shift amount is (3 − size) × 8, so it is always a multiple of 8.
- R3: The request write data equals the data-register value shifted left by the shift amount.
- R4: When instruction bit 29 is 1 (store), the write mask is 0xFFFFFFFF shifted left by the shift amount. When bit 29 is 0 (load), the write mask is zero.
- R5: The read mask is 0xFFFFFFFF for index 0, 1, 3 and 7. It is 0x000000FF for index 4, 0x0000FFFF for index 5, and zero for index 2 and 6.
- R6: The destination register is instruction bits [20:16] for a load and 0 for a store.
- R7: The request valid output is high for exactly the one cycle after each cycle in which in_valid is high. The held request fields do not change in a cycle that follows one with in_valid low.
- R8: When the held read mask is all ones, the load result is the returned word shifted right arithmetically by the held shift amount. This sign-extends from the access width.
- R9: When the held read mask is not all ones, the load result is the returned word shifted right logically by the held shift amount and then ANDed with the read mask.
- R10: While reset is asserted, request valid and every held request field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction accepted this cycle |
| instr | input | 32 | Load/store instruction word |
| base_val | input | 32 | Base register value |
| store_val | input | 32 | Data register value for stores |
| req_valid | output | 1 | Request issued (one-cycle pulse) |
| req_addr | output | 32 | Effective address |
| req_wdata | output | 32 | Store data in byte position |
| req_wmask | output | 32 | Write mask, zero for loads |
| req_rshift | output | 5 | Right-shift amount for returned data |
| req_rmask | output | 32 | Read mask / extension selector |
| req_dest | output | 5 | Destination register, zero for stores |
| rd_data | input | 32 | Word returned by memory |
| rd_result | output | 32 | Shifted and extended load value |

## Verification
In one cycle, the return path can be formatting memory data for the request already held while a new instruction is being accepted at the input. The bench sets this up by driving a new instruction with in_valid high and, in the same cycle, a returned word that belongs to the earlier request. Before the clock edge, rd_result must follow the shift and mask of the earlier request. After the edge, the request fields must show the new instruction. Loads of all eight index values and stores of three sizes come from a table and are compared against a model written from the requirements.

// File: rtl/lsf_pkg.sv
// Package: shared widths, request record and the index-to-read-mask rule
// for the scalar load/store request formatter.
package lsf_pkg;
    localparam int WORD_W = 32;
    localparam int REG_AW = 5;
    localparam int SH_W   = $clog2(WORD_W);
    localparam int IDX_W  = 3;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] wmask;
        logic [SH_W-1:0]   rshift;
        logic [WORD_W-1:0] rmask;
        logic [REG_AW-1:0] dest;
    } lsf_req_t;

    // Read mask chosen by the request index: all ones means sign-extend.
    function automatic logic [WORD_W-1:0] idx_to_rmask(input logic [IDX_W-1:0] idx);
        logic [WORD_W-1:0] m;
        case (idx)
            3'd0, 3'd1, 3'd3, 3'd7: m = '1;
            3'd4:                   m = {{(WORD_W-8){1'b0}}, 8'hFF};
            3'd5:                   m = {{(WORD_W-16){1'b0}}, 16'hFFFF};
            default:                m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/lsf_decode.sv
// Module: lsf_decode
// Purely combinational. Turns an instruction, a base value and a store value
// into an unregistered request record.
// Assumes: instr[29] = store, instr[28:26] = request index,
// instr[20:16] = data register, instr[15:0] = signed offset.
module lsf_decode
    import lsf_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] base_val,
    input  logic [WORD_W-1:0] store_val,
    output lsf_req_t          req
);
    logic [IDX_W-1:0]  idx;
    logic [1:0]        size_code;
    logic [SH_W-1:0]   shamt;
    logic              is_store;
    logic [WORD_W-1:0] offset;

    // Field extraction and lane placement for data and mask.
    always_comb begin
        idx       = instr[28:26];
        size_code = idx[1:0];
        is_store  = instr[29];
        shamt     = SH_W'({2'd3 - size_code, 3'b000});
        offset    = {{(WORD_W-16){instr[15]}}, instr[15:0]};
        req.addr   = base_val + offset;
        req.wdata  = store_val << shamt;
        req.wmask  = is_store ? ({WORD_W{1'b1}} << shamt) : '0;
        req.rshift = shamt;
        req.rmask  = idx_to_rmask(idx);
        req.dest   = is_store ? '0 : instr[20:16];
    end
endmodule

// File: rtl/lsf_req_reg.sv
// Module: lsf_req_reg
// Holds the request produced by the decoder. Loads a new one only when
// in_valid is high, and raises valid for one cycle after each load.
// Assumes: synchronous active-low reset clears valid and all fields.
module lsf_req_reg
    import lsf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  lsf_req_t d,
    output logic     q_valid,
    output lsf_req_t q
);
    // Capture the request and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) q <= d;
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> q_valid);
    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !q_valid);
    // R7
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(q));
endmodule

// File: rtl/lsf_return.sv
// Module: lsf_return
// Combinational formatter for returned load data. Shifts the word right by
// the held amount, then either sign-extends it (read mask all ones) or masks it.
// Assumes: the accessed bytes sit in the top lanes of rd_data.
module lsf_return
    import lsf_pkg::*;
(
    input  logic [WORD_W-1:0] rd_data,
    input  logic [SH_W-1:0]   rshift,
    input  logic [WORD_W-1:0] rmask,
    output logic [WORD_W-1:0] result
);
    logic sext_sel;

    // Choose arithmetic shift or logical shift plus mask.
    always_comb begin
        sext_sel = &rmask;
        if (sext_sel) result = WORD_W'($signed(rd_data) >>> rshift);
        else          result = (rd_data >> rshift) & rmask;
    end
endmodule

// File: rtl/lsu_req_fmt.sv
// Module: lsu_req_fmt (top)
// Scalar load/store request formatter. Decode, then a request register,
// then a return-data formatter driven by the held request.
// Assumes: one instruction per cycle at most; memory returns data aligned to
// the word in which the access was placed.
module lsu_req_fmt
    import lsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] base_val,
    input  logic [WORD_W-1:0] store_val,
    output logic              req_valid,
    output logic [WORD_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] req_wmask,
    output logic [SH_W-1:0]   req_rshift,
    output logic [WORD_W-1:0] req_rmask,
    output logic [REG_AW-1:0] req_dest,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] rd_result
);
    lsf_req_t dec_req;
    lsf_req_t held;

    lsf_decode u_dec (
        .instr(instr), .base_val(base_val), .store_val(store_val), .req(dec_req)
    );

    lsf_req_reg u_reg (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .d(dec_req), .q_valid(req_valid), .q(held)
    );

    lsf_return u_ret (
        .rd_data(rd_data), .rshift(held.rshift), .rmask(held.rmask), .result(rd_result)
    );

    // Break out the held record onto the ports.
    always_comb begin
        req_addr   = held.addr;
        req_wdata  = held.wdata;
        req_wmask  = held.wmask;
        req_rshift = held.rshift;
        req_rmask  = held.rmask;
        req_dest   = held.dest;
    end

    // R2
    shift_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_rshift[2:0] == 3'd0));
    // R4
    load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dest != '0) |-> (req_wmask == '0));
    // R6
    store_no_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wmask != '0) |-> (req_dest == '0));
    // R8
    sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (&req_rmask) && rd_data[WORD_W-1]) |-> rd_result[WORD_W-1]);
endmodule

// File: tb/sim_lsu_req_fmt.sv
module sim_lsu_req_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, base_val = '0, store_val = '0, rd_data = '0;
    logic        req_valid;
    logic [31:0] req_addr, req_wdata, req_wmask, req_rmask, rd_result;
    logic [4:0]  req_rshift, req_dest;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    lsu_req_fmt u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .base_val(base_val), .store_val(store_val), .req_valid(req_valid),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .req_rshift(req_rshift), .req_rmask(req_rmask), .req_dest(req_dest),
        .rd_data(rd_data), .rd_result(rd_result)
    );

    typedef struct packed {
        logic        st;
        logic [2:0]  idx;
        logic [4:0]  rt;
        logic [15:0] imm;
        logic [31:0] base;
        logic [31:0] stv;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 5'd3,  16'hFFFC, 32'h0000_0100, 32'h0,          32'h8012_3456},
        '{1'b0, 3'd1, 5'd4,  16'h0010, 32'h0000_1000, 32'h0,          32'hF00D_1234},
        '{1'b0, 3'd3, 5'd5,  16'h0000, 32'h0000_2000, 32'h0,          32'hDEAD_BEEF},
        '{1'b0, 3'd4, 5'd6,  16'h7FFF, 32'h0000_0000, 32'h0,          32'h9A00_0000},
        '{1'b0, 3'd5, 5'd7,  16'h8000, 32'h0001_0000, 32'h0,          32'hCAFE_0000},
        '{1'b0, 3'd2, 5'd8,  16'h0004, 32'h0000_0040, 32'h0,          32'hFFFF_FFFF},
        '{1'b0, 3'd6, 5'd9,  16'h0008, 32'h0000_0080, 32'h0,          32'h1234_5678},
        '{1'b0, 3'd7, 5'd10, 16'h000C, 32'h0000_00C0, 32'h0,          32'h8765_4321},
        '{1'b0, 3'd0, 5'd11, 16'h0001, 32'h0000_0300, 32'h0,          32'h7F00_0000},
        '{1'b1, 3'd0, 5'd12, 16'h0002, 32'h0000_0400, 32'h0000_00AB, 32'h0},
        '{1'b1, 3'd1, 5'd13, 16'hFFFE, 32'h0000_0500, 32'h1234_BEEF, 32'h0},
        '{1'b1, 3'd3, 5'd14, 16'h0020, 32'h0000_0600, 32'h0BAD_F00D, 32'h0}
    };

    function automatic logic [31:0] mk_instr(logic st, logic [2:0] idx, logic [4:0] rt, logic [15:0] imm);
        return {1'b1, 1'b0, st, idx, 5'd0, rt, imm};
    endfunction

    function automatic logic [4:0] m_shift(logic [2:0] idx);
        case (idx[1:0])
            2'd0: return 5'd24;
            2'd1: return 5'd16;
            2'd2: return 5'd8;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic [31:0] m_rmask(logic [2:0] idx);
        case (idx)
            3'd4: return 32'h0000_00FF;
            3'd5: return 32'h0000_FFFF;
            3'd2, 3'd6: return 32'h0;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] m_result(logic [2:0] idx, logic [31:0] rd);
        logic [4:0] sh = m_shift(idx);
        logic [31:0] msk = m_rmask(idx);
        if (msk == 32'hFFFF_FFFF) return 32'($signed(rd) >>> sh);
        return (rd >> sh) & msk;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic drive(vec_t v);
        instr = mk_instr(v.st, v.idx, v.rt, v.imm);
        base_val = v.base;
        store_val = v.stv;
        in_valid = 1'b1;
    endtask

    task automatic check_vec(vec_t v);
        logic [4:0] sh = m_shift(v.idx);
        chk("R7", "valid", {31'b0, req_valid}, 32'd1);
        chk("R1", "addr", req_addr, v.base + {{16{v.imm[15]}}, v.imm});
        chk("R2", "rshift", {27'b0, req_rshift}, {27'b0, sh});
        chk("R3", "wdata", req_wdata, v.stv << sh);
        chk("R4", "wmask", req_wmask, v.st ? (32'hFFFF_FFFF << sh) : 32'h0);
        chk("R5", "rmask", req_rmask, m_rmask(v.idx));
        chk("R6", "dest", {27'b0, req_dest}, v.st ? 32'h0 : {27'b0, v.rt});
        rd_data = v.rd;
        #1;
        if (m_rmask(v.idx) == 32'hFFFF_FFFF)
            chk("R8", "sext result", rd_result, m_result(v.idx, v.rd));
        else
            chk("R9", "masked result", rd_result, m_result(v.idx, v.rd));
    endtask

    initial begin
        // R10: reset state
        repeat (2) @(negedge clk);
        chk("R10", "valid in reset", {31'b0, req_valid}, 32'd0);
        chk("R10", "addr in reset", req_addr, 32'h0);
        chk("R10", "dest in reset", {27'b0, req_dest}, 32'h0);
        chk("R10", "rmask in reset", req_rmask, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check_vec(VEC[i]);
        end

        // R7: fields hold and valid drops while in_valid is low
        @(negedge clk);
        instr = mk_instr(1'b0, 3'd0, 5'd1, 16'h1111);
        base_val = 32'h5555_0000;
        repeat (2) @(negedge clk);
        chk("R7", "valid low when idle", {31'b0, req_valid}, 32'd0);
        chk("R7", "addr held when idle", req_addr, VEC[NV-1].base + 32'h20);

        // R1: address wrap and negative offset
        drive('{1'b0, 3'd3, 5'd2, 16'h0010, 32'hFFFF_FFF0, 32'h0, 32'h0});
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "addr wrap", req_addr, 32'h0);
        drive('{1'b0, 3'd3, 5'd2, 16'h8000, 32'h0000_0000, 32'h0, 32'h0});
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "addr most negative offset", req_addr, 32'hFFFF_8000);

        // Overlap: new instruction accepted while data returns for the held one
        drive(VEC[0]);                      // signed byte load held
        @(negedge clk);
        drive(VEC[4]);                      // unsigned half load arrives
        rd_data = 32'hC300_0000;
        #1;
        chk("R8", "overlap old format", rd_result, 32'hFFFF_FFC3);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "overlap new addr", req_addr, VEC[4].base + 32'hFFFF_8000);
        rd_data = 32'hC300_0000;
        #1;
        chk("R9", "overlap new format", rd_result, 32'h0000_C300);

        // R7: back-to-back requests keep valid high each cycle
        drive(VEC[9]);
        @(negedge clk);
        drive(VEC[10]);
        chk("R7", "first of pair valid", {31'b0, req_valid}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7", "second of pair valid", {31'b0, req_valid}, 32'd1);
        chk("R4", "second of pair wmask", req_wmask, 32'hFFFF_0000);
        @(negedge clk);
        chk("R7", "valid drops after pair", {31'b0, req_valid}, 32'd0);

        // R10: reset mid-run clears held request
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", "wmask after reset", req_wmask, 32'h0);
        chk("R10", "valid after reset", {31'b0, req_valid}, 32'd0);

        finish_run();
    end
endmodule